// File: doc/BRIEF.md
# Constant Buffer Streaming Uploader

This block sits on the method stream of a graphics command engine. It gathers runs of data words aimed at a constant buffer and turns each run into a single memory block write. Three state registers are written through methods: the buffer base address, the buffer size and a running byte position. A range of sixteen data methods selects a slot. The first word sent to any of these methods opens a burst. Further words to the same method are appended to that burst.

The first method that differs from the burst's method closes the burst. This may be any method, including a register method or one the block does not decode. The block then emits the collected block on a valid/ready output stream. Every beat of a block carries the block's target address, its byte length, an error flag and the slot number, together with one captured word. The final beat is marked. While the block drains, the input stream is held off. Once the drain ends, the method that closed the burst is accepted and handled normally.

The capture store has a fixed depth. A same-method word that arrives when the store is full closes the burst as well. That word then opens a new burst.

Top module: `cbuf_stream_upload`

## Requirements
- R1: After reset, o_valid is 0, no burst is open, and m_ready is 1.
- R2: A data method lies in DATA_BASE to DATA_BASE+NUM_SLOTS-1. Its slot is the method minus DATA_BASE, and that slot appears on o_slot for every beat of the block it opened.
- R3: When a burst opens, the current byte position is latched as the burst start and the word count restarts. Every accepted data word is stored and advances the position by 4.
- R4: Data words sent to the method of the open burst are appended. While no other method arrives, they produce no output beat.
- R5: While a burst is open, a different method stalls the input, flushes the burst as one block, and is then accepted and processed normally. A method that is not decoded still closes the burst and has no other effect.
- R6: A block's o_addr is the base plus the latched start, and o_len is the position minus the start, in bytes. The block has o_len/4 beats carrying the words in arrival order, with o_last set on the final beat only.
- R7: o_err is 1 for a block when the base at flush time is zero, or when the position exceeds the size. Position equal to size is not an error.
- R8: m_ready is 0 whenever o_valid is 1. While o_valid is 1 and o_ready is 0, every output holds its value.
- R9: The store holds DEPTH words. A same-method word arriving with DEPTH words stored first flushes the burst, then opens a new burst whose start is the advanced position.
- R10: Method M_BASE loads the base, M_SIZE loads the size and M_POS loads the position, each from the data word. The position continues from its advanced value after a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 1 | Method write present |
| m_ready | output | 1 | Method write accepted on this edge when high with m_valid |
| m_method | input | METHOD_W | Method number |
| m_data | input | DATA_W | Method argument |
| o_valid | output | 1 | Output beat valid |
| o_ready | input | 1 | Output beat taken |
| o_addr | output | ADDR_W | Block target address (base + start) |
| o_len | output | POS_W | Block length in bytes |
| o_err | output | 1 | Zero base or position past size at flush |
| o_slot | output | log2(NUM_SLOTS) | Data slot of the block |
| o_data | output | DATA_W | Captured word for this beat |
| o_last | output | 1 | Final beat of the block |

## Verification
The bench builds the block with DEPTH=4 and keeps the default sixteen slots and 16-bit position. The shallow store lets ordinary random bursts cross the capacity limit often, so overflow flushes and back-to-back blocks from one method occur many times. With the narrow position, small random sizes put position-past-size errors and the exact position-equals-size boundary within a few dozen words.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
    typedef enum logic [2:0] {
        MK_OTHER = 3'd0,
        MK_BASE  = 3'd1,
        MK_SIZE  = 3'd2,
        MK_POS   = 3'd3,
        MK_DATA  = 3'd4
    } mkind_t;
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
    import cbu_pkg::*;
#(
    parameter int METHOD_W  = 12,
    parameter int NUM_SLOTS = 16,
    parameter int DATA_BASE = 'h100,
    parameter int M_BASE    = 'h010,
    parameter int M_SIZE    = 'h011,
    parameter int M_POS     = 'h012
) (
    input  logic [METHOD_W-1:0]          method,
    output mkind_t                       kind,
    output logic [$clog2(NUM_SLOTS)-1:0] slot
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam logic [METHOD_W-1:0] LO = METHOD_W'(DATA_BASE);
    localparam logic [METHOD_W:0]   HI = (METHOD_W+1)'(DATA_BASE + NUM_SLOTS);

    logic [METHOD_W-1:0] offs;

    always_comb begin
        offs = method - LO;
        slot = SLOT_W'(offs);
        if (method >= LO && {1'b0, method} < HI)         kind = MK_DATA;
        else if (method == METHOD_W'(M_BASE))            kind = MK_BASE;
        else if (method == METHOD_W'(M_SIZE))            kind = MK_SIZE;
        else if (method == METHOD_W'(M_POS))             kind = MK_POS;
        else                                             kind = MK_OTHER;
    end
endmodule

// File: rtl/cbu_wordbuf.sv
module cbu_wordbuf #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DATA_W-1:0] ent_d;
        always_comb begin
            ent_d = ent_q[i];
            if (we && widx == IDX_W'(i)) ent_d = wdata;
        end
        always_ff @(posedge clk) begin
            ent_q[i] <= ent_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (ridx == IDX_W'(k)) rdata = ent_q[k];
        end
    end
endmodule

// File: rtl/cbu_drain.sv
module cbu_drain #(
    parameter int ADDR_W = 32,
    parameter int POS_W  = 16,
    parameter int SLOT_W = 4,
    parameter int CNT_W  = 5,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [POS_W-1:0]  st_len,
    input  logic              st_err,
    input  logic [SLOT_W-1:0] st_slot,
    input  logic [CNT_W-1:0]  st_beats,
    input  logic              o_ready,
    output logic              o_valid,
    output logic              o_last,
    output logic [ADDR_W-1:0] o_addr,
    output logic [POS_W-1:0]  o_len,
    output logic              o_err,
    output logic [SLOT_W-1:0] o_slot,
    output logic [IDX_W-1:0]  rd_idx
);
    typedef struct packed {
        logic              act;
        logic [CNT_W-1:0]  idx;
        logic [CNT_W-1:0]  beats;
        logic [ADDR_W-1:0] addr;
        logic [POS_W-1:0]  len;
        logic              err;
        logic [SLOT_W-1:0] slot;
    } dr_t;

    dr_t dr_d, dr_q;
    logic is_last;

    always_comb begin
        dr_d    = dr_q;
        is_last = (dr_q.idx + CNT_W'(1)) == dr_q.beats;
        if (start) begin
            dr_d.act   = 1'b1;
            dr_d.idx   = '0;
            dr_d.beats = st_beats;
            dr_d.addr  = st_addr;
            dr_d.len   = st_len;
            dr_d.err   = st_err;
            dr_d.slot  = st_slot;
        end else if (dr_q.act && o_ready) begin
            if (is_last) dr_d.act = 1'b0;
            else         dr_d.idx = dr_q.idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dr_q <= '0;
        else        dr_q <= dr_d;
    end

    assign o_valid = dr_q.act;
    assign o_last  = dr_q.act && is_last;
    assign o_addr  = dr_q.addr;
    assign o_len   = dr_q.len;
    assign o_err   = dr_q.err;
    assign o_slot  = dr_q.slot;
    assign rd_idx  = IDX_W'(dr_q.idx);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_addr) && $stable(o_len)
                                   && $stable(o_err) && $stable(o_slot) && $stable(rd_idx)));
    // R6
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_ready && o_last) |=> !o_valid);
endmodule

// File: rtl/cbuf_stream_upload.sv
module cbuf_stream_upload
    import cbu_pkg::*;
#(
    parameter int METHOD_W  = 12,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int POS_W     = 16,
    parameter int DEPTH     = 16,
    parameter int NUM_SLOTS = 16,
    parameter int DATA_BASE = 'h100,
    parameter int M_BASE    = 'h010,
    parameter int M_SIZE    = 'h011,
    parameter int M_POS     = 'h012
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         m_valid,
    output logic                         m_ready,
    input  logic [METHOD_W-1:0]          m_method,
    input  logic [DATA_W-1:0]            m_data,
    output logic                         o_valid,
    input  logic                         o_ready,
    output logic [ADDR_W-1:0]            o_addr,
    output logic [POS_W-1:0]             o_len,
    output logic                         o_err,
    output logic [$clog2(NUM_SLOTS)-1:0] o_slot,
    output logic [DATA_W-1:0]            o_data,
    output logic                         o_last
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [METHOD_W:0] IDLE_MARK = {1'b1, {METHOD_W{1'b0}}};

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [POS_W-1:0]   size;
        logic [POS_W-1:0]   pos;
        logic [POS_W-1:0]   start;
        logic [METHOD_W:0]  cur;
        logic [SLOT_W-1:0]  slot;
        logic [CNT_W-1:0]   cnt;
    } st_t;

    st_t st_d, st_q;

    mkind_t             kind;
    logic [SLOT_W-1:0]  dec_slot;
    logic               burst_open, same_m, full, need_flush, flush_go, m_fire;
    logic               draining, wr_en;
    logic [IDX_W-1:0]   rd_idx;
    logic [ADDR_W-1:0]  fl_addr;
    logic [POS_W-1:0]   fl_len;
    logic               fl_err;

    cbu_decode #(
        .METHOD_W (METHOD_W), .NUM_SLOTS(NUM_SLOTS), .DATA_BASE(DATA_BASE),
        .M_BASE   (M_BASE),   .M_SIZE   (M_SIZE),    .M_POS    (M_POS)
    ) u_dec (
        .method (m_method),
        .kind   (kind),
        .slot   (dec_slot)
    );

    always_comb begin
        st_d       = st_q;
        burst_open = !st_q.cur[METHOD_W];
        same_m     = burst_open && (st_q.cur[METHOD_W-1:0] == m_method);
        full       = (st_q.cnt == CNT_W'(DEPTH));
        need_flush = burst_open && (!same_m || full);
        m_ready    = !draining && !need_flush;
        m_fire     = m_valid && m_ready;
        flush_go   = m_valid && !draining && need_flush;
        wr_en      = m_fire && (kind == MK_DATA);
        fl_addr    = st_q.base + ADDR_W'(st_q.start);
        fl_len     = st_q.pos - st_q.start;
        fl_err     = (st_q.base == '0) || (st_q.pos > st_q.size);

        if (flush_go) begin
            st_d.cur = IDLE_MARK;
            st_d.cnt = '0;
        end else if (m_fire) begin
            unique case (kind)
                MK_BASE: st_d.base = ADDR_W'(m_data);
                MK_SIZE: st_d.size = POS_W'(m_data);
                MK_POS:  st_d.pos  = POS_W'(m_data);
                MK_DATA: begin
                    if (!burst_open) begin
                        st_d.cur   = {1'b0, m_method};
                        st_d.slot  = dec_slot;
                        st_d.start = st_q.pos;
                    end
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                    st_d.pos = st_q.pos + POS_W'(4);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cur  <= IDLE_MARK;
        end else begin
            st_q <= st_d;
        end
    end

    cbu_wordbuf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
        .clk   (clk),
        .we    (wr_en),
        .widx  (IDX_W'(st_q.cnt)),
        .wdata (m_data),
        .ridx  (rd_idx),
        .rdata (o_data)
    );

    cbu_drain #(
        .ADDR_W(ADDR_W), .POS_W(POS_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (flush_go),
        .st_addr  (fl_addr),
        .st_len   (fl_len),
        .st_err   (fl_err),
        .st_slot  (st_q.slot),
        .st_beats (st_q.cnt),
        .o_ready  (o_ready),
        .o_valid  (o_valid),
        .o_last   (o_last),
        .o_addr   (o_addr),
        .o_len    (o_len),
        .o_err    (o_err),
        .o_slot   (o_slot),
        .rd_idx   (rd_idx)
    );

    assign draining = o_valid;

    // R8
    stall_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> !m_ready);
    // R5
    flush_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_go |=> (o_valid && st_q.cur[METHOD_W]));
    // R3
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && kind == MK_DATA) |=> (st_q.pos == $past(st_q.pos) + POS_W'(4)));
    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
endmodule

// File: tb/cbuf_stream_upload_bench.sv
module cbuf_stream_upload_bench;
    localparam int MW = 12, DW = 32, AW = 32, PW = 16, DEP = 4, NS = 16;
    localparam int DB = 'h100, MB = 'h010, MSZ = 'h011, MP = 'h012, MOTH = 'h050;

    logic clk = 0, rst_n = 0;
    logic m_valid = 0, m_ready;
    logic [MW-1:0] m_method = '0;
    logic [DW-1:0] m_data = '0;
    logic o_valid, o_ready = 0, o_err, o_last;
    logic [AW-1:0] o_addr;
    logic [PW-1:0] o_len;
    logic [3:0]    o_slot;
    logic [DW-1:0] o_data;

    always #2 clk = ~clk;

    cbuf_stream_upload #(
        .METHOD_W(MW), .DATA_W(DW), .ADDR_W(AW), .POS_W(PW), .DEPTH(DEP), .NUM_SLOTS(NS),
        .DATA_BASE(DB), .M_BASE(MB), .M_SIZE(MSZ), .M_POS(MP)
    ) u_cbuf_stream_upload (
        .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_method(m_method),
        .m_data(m_data), .o_valid(o_valid), .o_ready(o_ready), .o_addr(o_addr), .o_len(o_len),
        .o_err(o_err), .o_slot(o_slot), .o_data(o_data), .o_last(o_last)
    );

    typedef struct {
        logic [AW-1:0] addr; logic [PW-1:0] len; logic err;
        logic [3:0] slot; logic [DW-1:0] data; logic last;
    } beat_t;

    beat_t exp_q[$];
    int checks = 0, fails = 0;
    bit finished = 0;
    int ready_pct = 75;

    // bench model state
    logic [AW-1:0] mb_base = '0;
    logic [PW-1:0] mb_size = '0, mb_pos = '0, mb_start = '0;
    bit mb_open = 0;
    logic [MW-1:0] mb_cur = '0;
    logic [DW-1:0] mb_words[$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_data(input logic [MW-1:0] m);
        return (int'(m) >= DB) && (int'(m) < DB + NS);
    endfunction

    task automatic model_flush();
        beat_t b;
        b.addr = mb_base + AW'(mb_start);
        b.len  = mb_pos - mb_start;
        b.err  = (mb_base == 0) || (mb_pos > mb_size);
        b.slot = 4'(int'(mb_cur) - DB);
        foreach (mb_words[i]) begin
            b.data = mb_words[i];
            b.last = (i == mb_words.size() - 1);
            exp_q.push_back(b);
        end
        mb_words.delete();
        mb_open = 0;
    endtask

    task automatic model_issue(input logic [MW-1:0] m, input logic [DW-1:0] d);
        if (mb_open && (m != mb_cur || mb_words.size() == DEP)) model_flush();
        if (int'(m) == MB) mb_base = d;
        else if (int'(m) == MSZ) mb_size = PW'(d);
        else if (int'(m) == MP) mb_pos = PW'(d);
        else if (is_data(m)) begin
            if (!mb_open) begin
                mb_open = 1; mb_cur = m; mb_start = mb_pos;
            end
            mb_words.push_back(d);
            mb_pos = mb_pos + 16'd4;
        end
    endtask

    task automatic send(input logic [MW-1:0] m, input logic [DW-1:0] d);
        model_issue(m, d);
        @(negedge clk);
        m_valid = 1; m_method = m; m_data = d;
        #1;
        while (!m_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        m_valid = 0;
    endtask

    task automatic drain_wait();
        int guard = 0;
        while ((exp_q.size() != 0 || o_valid) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    // output ready driver
    initial begin
        forever begin
            @(posedge clk);
            #1;
            o_ready = ($urandom % 100) < ready_pct;
        end
    end

    // output monitor
    beat_t prev;
    bit prev_stall = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (o_valid) chk(!m_ready, "R8 m_ready during drain", m_ready, 0);
            if (prev_stall) begin
                chk(o_valid && o_addr == prev.addr && o_len == prev.len && o_data == prev.data
                    && o_last == prev.last && o_slot == prev.slot && o_err == prev.err,
                    "R8 hold under backpressure", o_data, prev.data);
            end
            prev_stall = o_valid && !o_ready;
            prev = '{o_addr, o_len, o_err, o_slot, o_data, o_last};
            if (o_valid && o_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected beat", o_data, 0);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    chk(o_addr == e.addr, "R6 addr", o_addr, e.addr);
                    chk(o_len == e.len, "R6 len", o_len, e.len);
                    chk(o_data == e.data, "R3 word", o_data, e.data);
                    chk(o_last == e.last, "R6 last", o_last, e.last);
                    chk(o_err == e.err, "R7 err", o_err, e.err);
                    chk(o_slot == e.slot, "R2 slot", o_slot, e.slot);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(o_valid == 0, "R1 o_valid after reset", o_valid, 0);
        chk(m_ready == 1, "R1 m_ready after reset", m_ready, 1);

        // R10 registers, R3 start latch, R4 append without output
        send(MW'(MB), 32'h0000_1000);
        send(MW'(MSZ), 32'h0000_0100);
        send(MW'(MP), 32'h0000_0020);
        send(MW'(DB + 5), 32'hAAAA_0001);
        send(MW'(DB + 5), 32'hAAAA_0002);
        send(MW'(DB + 5), 32'hAAAA_0003);
        repeat (4) begin
            @(negedge clk);
            chk(o_valid == 0, "R4 no output while appending", o_valid, 0);
        end
        // R5 undecoded method closes the burst
        send(MW'(MOTH), 32'h1234);
        drain_wait();
        chk(exp_q.size() == 0, "R5 block drained", exp_q.size(), 0);

        // R10 position continues: next burst starts at 0x2C
        send(MW'(DB + 15), 32'hBBBB_0001);
        send(MW'(DB + 0), 32'hCCCC_0001);
        send(MW'(MP), 32'h0);
        drain_wait();

        // R9 capacity: 6 words -> blocks of 4 and 2
        send(MW'(MP), 32'h40);
        for (int i = 0; i < 6; i++) send(MW'(DB + 2), 32'hD000_0000 + 32'(i));
        send(MW'(MOTH), 0);
        drain_wait();
        chk(exp_q.size() == 0, "R9 two blocks drained", exp_q.size(), 0);

        // R7 zero base; then position equals size (no error); then past size
        send(MW'(MB), 0);
        send(MW'(DB + 1), 32'hE1);
        send(MW'(MB), 32'h8000);
        send(MW'(MSZ), 32'h8);
        send(MW'(MP), 0);
        send(MW'(DB + 1), 32'hE2);
        send(MW'(DB + 1), 32'hE3);
        send(MW'(DB + 3), 32'hE4);
        send(MW'(MOTH), 0);
        drain_wait();
        chk(exp_q.size() == 0, "R7 error blocks drained", exp_q.size(), 0);

        // random mix
        send(MW'(MSZ), 32'h80);
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom % 100;
            ready_pct = (n % 100 < 50) ? 90 : 40;
            if (r < 8)       send(MW'(MB), ($urandom % 4 == 0) ? 0 : $urandom);
            else if (r < 14) send(MW'(MSZ), $urandom % 'h100);
            else if (r < 18) send(MW'(MP), ($urandom % 32) * 4);
            else if (r < 22) send(MW'(MOTH), $urandom);
            else if (r < 30) send(MW'(DB + ($urandom % NS)), $urandom);
            else             send(MW'(DB + ($urandom % 3)), $urandom);
        end
        send(MW'(MOTH), 0);
        ready_pct = 75;
        drain_wait();
        chk(exp_q.size() == 0, "R5 random blocks drained", exp_q.size(), 0);
        chk(o_valid == 0, "R6 output idle at end", o_valid, 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule